// File: doc/BRIEF.md
# Network Interrupt Status Aggregator

This block gathers per-port interrupt requests coming from plug-in module slots and folds them into one level-sensitive network interrupt line for the CPU. Each request arrives as a set or clear event naming a slot and one of that slot's four ports. The event turns into a single bit in a status word. Which bit it lands on comes from a fixed per-slot base offset plus the port number.

A layout input selects between two chassis arrangements. The quad layout has four slots, all packed into one 32-bit word. The septet layout has seven slots: six share the first word at scattered nibble positions, and slot 0 sits alone at the bottom of a second word. Software reads the status through a combinational read port indexed by offset. In the quad layout the word is exposed as four byte-wide views. In the septet layout it is exposed as two full-word views.

Top module: `netirq_agg`

## Requirements
- R1: While `rst` is high, both status words clear to zero, so `irq_out` is low and every read view returns zero.
- R2: With `layout` = 0 (quad), slots 0, 1, 2 and 3 map to base bits 16, 24, 0 and 8 of status word 0. Word 1 is never modified in this layout.
- R3: With `layout` = 1 (septet), slots 1 through 6 map to base bits 24, 16, 28, 20, 8 and 0 of word 0. Slot 0 maps to base bit 0 of word 1.
- R4: The port number (0 to 3) is added to the slot's base bit to select the status bit.
- R5: A clear event removes only its selected bit and leaves every other bit as it was.
- R6: When a set event and a clear event select the same bit in the same cycle, the bit ends up set.
- R7: Events naming slots 4 to 7 in the quad layout, or slot 7 in the septet layout, change no status bit.
- R8: `irq_out` is high exactly when an active word is nonzero. Word 0 is always active; word 1 is active only in the septet layout.
- R9: In the quad layout, offsets 0x20000, 0x20001, 0x20002 and 0x20003 return bits 31:24, 23:16, 15:8 and 7:0 of word 0, zero-extended.
- R10: In the septet layout, offset 0x10010 returns all of word 0 and offset 0x20010 returns word 1. Any offset not valid in the current layout reads zero.
- R11: An event sampled on a rising clock edge is visible on the read port and on `irq_out` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layout | input | 1 | 0 = quad-slot layout, 1 = septet-slot layout |
| set_vld | input | 1 | Set event valid |
| set_slot | input | 3 | Slot of the set event |
| set_port | input | 2 | Port of the set event |
| clr_vld | input | 1 | Clear event valid |
| clr_slot | input | 3 | Slot of the clear event |
| clr_port | input | 2 | Port of the clear event |
| rd_addr | input | 18 | Read offset |
| rd_data | output | 32 | Read data (combinational) |
| irq_out | output | 1 | Combined network interrupt, level |

## Verification
The checker watches several properties on every cycle: the quiet interrupt while all status is zero, set priority and clear isolation for one slot, the immunity of word 1 in the quad layout, and the absence of any effect from unmapped slots. Only the bench's scenarios can show that every slot lands on its exact bit in both layouts and that the byte views are in their swapped order. The same holds for the masking of word 1 from the interrupt after a layout change, and for zero reads at offsets outside the current layout.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int SLOT_W   = 3;
    localparam int PORT_W   = 2;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 2;
    localparam int BIDX_W   = $clog2(WORD_W);
    localparam int ADDR_W   = 18;
    localparam int BYTE_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_Q_B3 = 18'h20000;
    localparam logic [ADDR_W-1:0] OFS_Q_B2 = 18'h20001;
    localparam logic [ADDR_W-1:0] OFS_Q_B1 = 18'h20002;
    localparam logic [ADDR_W-1:0] OFS_Q_B0 = 18'h20003;
    localparam logic [ADDR_W-1:0] OFS_S_W0 = 18'h10010;
    localparam logic [ADDR_W-1:0] OFS_S_W1 = 18'h20010;

    typedef enum logic {
        LAYOUT_QUAD = 1'b0,
        LAYOUT_SEPT = 1'b1
    } layout_e;

    typedef struct packed {
        logic              hit;
        logic              word;
        logic [BIDX_W-1:0] base;
    } slot_map_t;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [PORT_W-1:0] port;
    } irq_evt_t;

    function automatic slot_map_t map_slot(layout_e lay, logic [SLOT_W-1:0] slot);
        slot_map_t m;
        m = '{hit: 1'b0, word: 1'b0, base: '0};
        if (lay == LAYOUT_QUAD) begin
            case (slot)
                3'd0: m = '{hit: 1'b1, word: 1'b0, base: 5'd16};
                3'd1: m = '{hit: 1'b1, word: 1'b0, base: 5'd24};
                3'd2: m = '{hit: 1'b1, word: 1'b0, base: 5'd0};
                3'd3: m = '{hit: 1'b1, word: 1'b0, base: 5'd8};
                default: m = '{hit: 1'b0, word: 1'b0, base: '0};
            endcase
        end else begin
            case (slot)
                3'd0: m = '{hit: 1'b1, word: 1'b1, base: 5'd0};
                3'd1: m = '{hit: 1'b1, word: 1'b0, base: 5'd24};
                3'd2: m = '{hit: 1'b1, word: 1'b0, base: 5'd16};
                3'd3: m = '{hit: 1'b1, word: 1'b0, base: 5'd28};
                3'd4: m = '{hit: 1'b1, word: 1'b0, base: 5'd20};
                3'd5: m = '{hit: 1'b1, word: 1'b0, base: 5'd8};
                3'd6: m = '{hit: 1'b1, word: 1'b0, base: 5'd0};
                default: m = '{hit: 1'b0, word: 1'b0, base: '0};
            endcase
        end
        return m;
    endfunction

    function automatic logic word_active(layout_e lay, int unsigned w);
        return (w == 0) || (lay == LAYOUT_SEPT);
    endfunction

endpackage

// File: rtl/netirq_evt_decode.sv
module netirq_evt_decode
    import netirq_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int WORDS = NWORDS
) (
    input  layout_e                     lay,
    input  irq_evt_t                    evt,
    output logic [WORDS-1:0][WIDTH-1:0] onehot
);
    slot_map_t         m;
    logic [BIDX_W-1:0] pos;

    always_comb begin
        m   = map_slot(lay, evt.slot);
        pos = m.base + BIDX_W'(evt.port);
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_comb begin
            onehot[w] = '0;
            if (evt.vld && m.hit && (int'(m.word) == w))
                onehot[w][pos] = 1'b1;
        end
    end
endmodule

// File: rtl/netirq_status_word.sv
module netirq_status_word #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/netirq_rd_view.sv
module netirq_rd_view
    import netirq_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int WORDS = NWORDS,
    parameter int AW    = ADDR_W
) (
    input  layout_e                     lay,
    input  logic [AW-1:0]               addr,
    input  logic [WORDS-1:0][WIDTH-1:0] words,
    output logic [WIDTH-1:0]            rdata
);
    localparam int NBYTES = WIDTH / BYTE_W;

    logic [NBYTES-1:0][BYTE_W-1:0] w0_bytes;
    assign w0_bytes = words[0];

    always_comb begin
        rdata = '0;
        if (lay == LAYOUT_QUAD) begin
            case (addr)
                OFS_Q_B3: rdata = WIDTH'(w0_bytes[3]);
                OFS_Q_B2: rdata = WIDTH'(w0_bytes[2]);
                OFS_Q_B1: rdata = WIDTH'(w0_bytes[1]);
                OFS_Q_B0: rdata = WIDTH'(w0_bytes[0]);
                default:  rdata = '0;
            endcase
        end else begin
            case (addr)
                OFS_S_W0: rdata = words[0];
                OFS_S_W1: rdata = words[1];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/netirq_agg.sv
module netirq_agg
    import netirq_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int WORDS = NWORDS,
    parameter int SW    = SLOT_W,
    parameter int PW    = PORT_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             layout,
    input  logic             set_vld,
    input  logic [SW-1:0]    set_slot,
    input  logic [PW-1:0]    set_port,
    input  logic             clr_vld,
    input  logic [SW-1:0]    clr_slot,
    input  logic [PW-1:0]    clr_port,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             irq_out
);
    layout_e                     lay;
    irq_evt_t                    set_evt, clr_evt;
    logic [WORDS-1:0][WIDTH-1:0] set_oh, clr_oh, stat_q;
    logic [WORDS-1:0]            word_hot;

    assign lay     = layout_e'(layout);
    assign set_evt = '{vld: set_vld, slot: set_slot, port: set_port};
    assign clr_evt = '{vld: clr_vld, slot: clr_slot, port: clr_port};

    netirq_evt_decode #(.WIDTH(WIDTH), .WORDS(WORDS)) u_set_dec (
        .lay(lay), .evt(set_evt), .onehot(set_oh)
    );
    netirq_evt_decode #(.WIDTH(WIDTH), .WORDS(WORDS)) u_clr_dec (
        .lay(lay), .evt(clr_evt), .onehot(clr_oh)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_stat
        netirq_status_word #(.WIDTH(WIDTH)) u_word (
            .clk(clk), .rst(rst),
            .set_vec(set_oh[w]), .clr_vec(clr_oh[w]),
            .q(stat_q[w])
        );
        assign word_hot[w] = word_active(lay, w) && (|stat_q[w]);
    end

    assign irq_out = |word_hot;

    netirq_rd_view #(.WIDTH(WIDTH), .WORDS(WORDS), .AW(AW)) u_view (
        .lay(lay), .addr(rd_addr), .words(stat_q), .rdata(rd_data)
    );
endmodule

// File: rtl/netirq_agg_chk.sv
module netirq_agg_chk #(
    parameter int WIDTH = 32,
    parameter int WORDS = 2,
    parameter int SW    = 3,
    parameter int PW    = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     layout,
    input logic                     set_vld,
    input logic [SW-1:0]            set_slot,
    input logic [PW-1:0]            set_port,
    input logic                     clr_vld,
    input logic [SW-1:0]            clr_slot,
    input logic [PW-1:0]            clr_port,
    input logic                     irq_out,
    input logic [WORDS-1:0][WIDTH-1:0] stat_q
);
    logic [PW-1:0] set_port_q, clr_port_q;
    always_ff @(posedge clk) begin
        set_port_q <= set_port;
        clr_port_q <= clr_port;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_out && stat_q == '0));

    // R8
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq_out);

    // R8
    quad_set_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vld && !layout && set_slot < 3'd4) |=> irq_out);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vld && clr_vld && !layout && set_slot == 3'd2 && clr_slot == 3'd2
         && set_port == clr_port) |=> stat_q[0][{3'b000, set_port_q}]);

    // R5
    clear_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !set_vld && !layout && clr_slot == 3'd2)
        |=> !stat_q[0][{3'b000, clr_port_q}]);

    // R7
    unmapped_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vld && !clr_vld && !layout && set_slot >= 3'd4) |=> $stable(stat_q));

    // R2
    quad_word1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !layout |=> $stable(stat_q[1]));
endmodule

bind netirq_agg netirq_agg_chk #(.WIDTH(WIDTH), .WORDS(WORDS), .SW(SW), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .layout(layout),
    .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
    .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
    .irq_out(irq_out), .stat_q(stat_q)
);

// File: tb/sim_netirq_agg.sv
module sim_netirq_agg;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        layout = 1'b0;
    logic        set_vld = 1'b0, clr_vld = 1'b0;
    logic [2:0]  set_slot = '0, clr_slot = '0;
    logic [1:0]  set_port = '0, clr_port = '0;
    logic [17:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    netirq_agg u0 (
        .clk(clk), .rst(rst), .layout(layout),
        .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
        .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        sv;
        logic [2:0]  ss;
        logic [1:0]  sp;
        logic        cv;
        logic [2:0]  cs;
        logic [1:0]  cp;
        logic [31:0] w0;
    } vec_t;

    // Quad layout walk; w0 is the expected word 0 after each step.
    localparam vec_t TBL [11] = '{
        '{1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 2'd0, 32'h0001_0000},  // R2 slot0
        '{1'b1, 3'd1, 2'd3, 1'b0, 3'd0, 2'd0, 32'h0801_0000},  // R2 R4 slot1 port3
        '{1'b1, 3'd2, 2'd1, 1'b0, 3'd0, 2'd0, 32'h0801_0002},  // R2 slot2
        '{1'b1, 3'd3, 2'd2, 1'b0, 3'd0, 2'd0, 32'h0801_0402},  // R2 slot3
        '{1'b1, 3'd5, 2'd0, 1'b0, 3'd0, 2'd0, 32'h0801_0402},  // R7 ignored
        '{1'b0, 3'd0, 2'd0, 1'b1, 3'd1, 2'd3, 32'h0001_0402},  // R5
        '{1'b1, 3'd3, 2'd3, 1'b1, 3'd3, 2'd3, 32'h0001_0C02},  // R6
        '{1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 2'd0, 32'h0000_0C02},  // R5
        '{1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 2'd1, 32'h0000_0C00},  // R5
        '{1'b0, 3'd0, 2'd0, 1'b1, 3'd3, 2'd2, 32'h0000_0800},  // R5
        '{1'b0, 3'd0, 2'd0, 1'b1, 3'd3, 2'd3, 32'h0000_0000}   // R5 R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic ev(input logic sv, input logic [2:0] ss, input logic [1:0] sp,
                      input logic cv, input logic [2:0] cs, input logic [1:0] cp);
        @(negedge clk);
        set_vld = sv; set_slot = ss; set_port = sp;
        clr_vld = cv; clr_slot = cs; clr_port = cp;
        @(negedge clk);
        set_vld = 1'b0; clr_vld = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd(18'h20001, d); chk("R1 view after reset", d, 32'h0);

        // Table walk, quad layout: R9 byte views, R8 irq, R11 one-edge latency
        for (int i = 0; i < 11; i++) begin
            ev(TBL[i].sv, TBL[i].ss, TBL[i].sp, TBL[i].cv, TBL[i].cs, TBL[i].cp);
            rd(18'h20000, d); chk($sformatf("R9 R11 row%0d b3", i), d, {24'b0, TBL[i].w0[31:24]});
            rd(18'h20001, d); chk($sformatf("R9 row%0d b2", i), d, {24'b0, TBL[i].w0[23:16]});
            rd(18'h20002, d); chk($sformatf("R9 row%0d b1", i), d, {24'b0, TBL[i].w0[15:8]});
            rd(18'h20003, d); chk($sformatf("R9 row%0d b0", i), d, {24'b0, TBL[i].w0[7:0]});
            chk($sformatf("R8 row%0d irq", i), {31'b0, irq_out}, {31'b0, TBL[i].w0 != 0});
        end
        // R10 invalid offset in quad layout
        ev(1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 2'd0);
        rd(18'h10010, d); chk("R10 sept offset in quad", d, 32'h0);
        rd(18'h20004, d); chk("R10 unknown offset", d, 32'h0);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd1, 2'd0);

        // Septet layout: R3 R4
        @(negedge clk); layout = 1'b1;
        ev(1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd2, 2'd1, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd3, 2'd2, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd4, 2'd3, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd5, 2'd0, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd6, 2'd1, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd0, 2'd2, 1'b0, 3'd0, 2'd0);
        ev(1'b1, 3'd7, 2'd3, 1'b0, 3'd0, 2'd0);  // R7 ignored
        rd(18'h10010, d); chk("R3 R10 sept word0", d, 32'h4182_0102);
        rd(18'h20010, d); chk("R3 R10 sept word1", d, 32'h0000_0004);
        rd(18'h20000, d); chk("R10 quad offset in sept", d, 32'h0);
        // R8 word1 alone keeps irq after word0 clears
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd1, 2'd0);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 2'd1);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd3, 2'd2);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd4, 2'd3);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd5, 2'd0);
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd6, 2'd1);
        rd(18'h10010, d); chk("R5 sept word0 cleared", d, 32'h0);
        chk("R8 word1 drives irq", {31'b0, irq_out}, 32'h1);
        // R8 word1 masked in quad layout
        @(negedge clk); layout = 1'b0;
        #0.5; chk("R8 word1 masked in quad", {31'b0, irq_out}, 32'h0);
        // R2 quad slot0 event goes to word0, word1 untouched
        ev(1'b1, 3'd0, 2'd1, 1'b0, 3'd0, 2'd0);
        rd(18'h20001, d); chk("R2 quad slot0 port1", d, 32'h0000_0002);
        @(negedge clk); layout = 1'b1;
        rd(18'h20010, d); chk("R2 word1 held in quad", d, 32'h0000_0004);
        // R5 clear word1 in septet
        ev(1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 2'd2);
        rd(18'h20010, d); chk("R5 sept word1 cleared", d, 32'h0);
        // R1 reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(18'h10010, d); chk("R1 word0 after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        summary();
    end
endmodule